// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block is the slave side of a 24-bit, big-endian processor bus. Each access carries a byte address, a transfer size (byte, word or long) and a read or write strobe. The block sends the access to one of four byte-wide storage regions: boot ROM, main RAM, video RAM or map RAM. An address that falls outside all four is handled as an I/O register access. Multi-byte data is assembled big-endian. The first byte address carries the most significant byte, and every byte address is masked by its own region's size, so an access wraps inside its region.

A one-bit mapping mode controls address translation. After reset the block is in boot mode, and bit 23 of every incoming address is forced high. Every access therefore lands in the ROM window, or in the I/O space above it. Software leaves boot mode by writing the mode control register. A word write to the LED register drives four active-low indicator outputs. A fill port lets the environment preload any region, including ROM, one byte per cycle.

The mode control is a two-state machine:
- MODE_BOOT: addresses are forced into the ROM window.
- MODE_NORMAL: addresses pass through unchanged.

There are two transitions:
- BOOT_TO_NORMAL fires on a control-register write whose flag bit is 1.
- NORMAL_TO_BOOT fires on a control-register write whose flag bit is 0.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the block is in boot mode, `led_n` is 4'hF (all LEDs off) and `rd_valid` is 0.
- R2: In boot mode, bit 23 of the address is forced to 1 before decoding. In normal mode the address is used unchanged.
- R3: Addresses 0x800000 to 0xBFFFFF select ROM, with offset = address AND (ROM_BYTES-1). Writes that select ROM change nothing.
- R4: After translation, regions are checked in a fixed priority order:
  - ROM first;
  - then main RAM, for addresses 0 to RAM_BYTES-1 (default 512 KiB), offset masked with RAM_BYTES-1;
  - then video RAM, 0x420000 to 0x427FFF, mask 0x7FFF;
  - then map RAM, 0x400000 to 0x4007FF, mask 0x7FF;
  - anything else is I/O.
- R5: A read that selects I/O returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R6: `bus_size` encodes 0 = byte, 1 = word, 2 = long. Data on `bus_wdata` and `rd_data` is right-justified, with unused upper bits of `rd_data` zero. The byte at the lowest address is the most significant byte.
- R7: Each byte of a multi-byte access uses address+k masked by its own region's mask, so the access wraps within that region.
- R8: A write whose translated address is 0xE43000 sets the mode. The flag is `bus_wdata[7]` for a byte write and `bus_wdata[15]` for a word or long write. A flag of 1 selects normal mode and 0 selects boot mode.
- R9: A word write whose translated address is 0x4A0000 loads `led_n` from `bus_wdata[11:8]`. Byte and long writes there leave `led_n` unchanged.
- R10: A read strobe in cycle t gives `rd_valid` high with `rd_data` in cycle t+1 only. A write completes in its own cycle. A write to any other I/O address changes no storage and no output.
- R11: Each region stores STORE_DEPTH bytes, and the low bits of the region offset select the location. `fill_en` writes `fill_byte` at location `fill_idx` of the region chosen by `fill_sel`: 0 = ROM, 1 = RAM, 2 = video RAM, 3 = map RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle (ignored while `bus_rd` is high) |
| bus_size | input | 2 | Transfer size: 0 = byte, 1 = word, 2 = long |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Right-justified write data |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | 32 | Registered, right-justified read data |
| led_n | output | 4 | Active-low LED register |
| fill_en | input | 1 | Preload strobe |
| fill_sel | input | 2 | Preload region select |
| fill_idx | input | STORE_AW | Preload byte location |
| fill_byte | input | 8 | Preload data |

## Verification
The bench goes after the mode change in both directions, using both flag positions. A design that reads the wrong bit for byte writes would stay in boot mode, and later RAM reads would return ROM bytes. It probes each region's edge addresses and the addresses just past them. A decoder with an off-by-one bound or the wrong priority would return stored bytes where all ones are expected, or the reverse. It also runs long accesses that straddle the top of video RAM and of ROM, and it writes ROM, the LED address with the wrong size, and unused I/O. A design that wrapped lanes wrongly, or did not discard these writes, would show wrong bytes or LED values on the next reads.

// File: rtl/bod_pkg.sv
package bod_pkg;

    localparam int BUS_AW = 24;
    localparam int BUS_DW = 32;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_WORD = 2'd1,
        XFER_LONG = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_t;

    typedef enum logic [2:0] {
        RGN_ROM  = 3'd0,
        RGN_RAM  = 3'd1,
        RGN_VRAM = 3'd2,
        RGN_MAP  = 3'd3,
        RGN_IO   = 3'd4
    } region_t;

    typedef enum logic {
        MODE_BOOT   = 1'b0,
        MODE_NORMAL = 1'b1
    } map_mode_t;

    localparam logic [BUS_AW-1:0] FORCE_HI  = 24'h800000;
    localparam logic [BUS_AW-1:0] ROM_LO    = 24'h800000;
    localparam logic [BUS_AW-1:0] ROM_HI    = 24'hBFFFFF;
    localparam logic [BUS_AW-1:0] VRAM_LO   = 24'h420000;
    localparam logic [BUS_AW-1:0] VRAM_HI   = 24'h427FFF;
    localparam logic [BUS_AW-1:0] VRAM_MASK = 24'h007FFF;
    localparam logic [BUS_AW-1:0] MAP_LO    = 24'h400000;
    localparam logic [BUS_AW-1:0] MAP_HI    = 24'h4007FF;
    localparam logic [BUS_AW-1:0] MAP_MASK  = 24'h0007FF;
    localparam logic [BUS_AW-1:0] CTRL_ADDR = 24'hE43000;
    localparam logic [BUS_AW-1:0] LED_ADDR  = 24'h4A0000;

    // Lanes touched by a transfer; lane 0 is the lowest byte address.
    function automatic logic [LANES-1:0] lane_mask(xfer_t sz);
        case (sz)
            XFER_BYTE: lane_mask = 4'b0001;
            XFER_WORD: lane_mask = 4'b0011;
            default:   lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/bod_region_decode.sv
module bod_region_decode
    import bod_pkg::*;
#(
    parameter int RAM_BYTES = 524288
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  map_mode_t         mode,
    output logic [BUS_AW-1:0] eff_addr,
    output region_t           region
);
    localparam logic [BUS_AW-1:0] RAM_LAST = BUS_AW'(RAM_BYTES - 1);

    always_comb begin
        eff_addr = (mode == MODE_NORMAL) ? bus_addr : (bus_addr | FORCE_HI);
        if (eff_addr >= ROM_LO && eff_addr <= ROM_HI)
            region = RGN_ROM;
        else if (eff_addr <= RAM_LAST)
            region = RGN_RAM;
        else if (eff_addr >= VRAM_LO && eff_addr <= VRAM_HI)
            region = RGN_VRAM;
        else if (eff_addr >= MAP_LO && eff_addr <= MAP_HI)
            region = RGN_MAP;
        else
            region = RGN_IO;
    end
endmodule

// File: rtl/bod_byte_store.sv
module bod_byte_store
    import bod_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     fill_en,
    input  logic [AW-1:0]            fill_idx,
    input  logic [7:0]               fill_byte,
    input  logic [LANES-1:0]         lane_we,
    input  logic [LANES-1:0][AW-1:0] lane_idx,
    input  logic [LANES-1:0][7:0]    lane_wbyte,
    output logic [LANES-1:0][7:0]    lane_rbyte
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (fill_en)
            mem[fill_idx] <= fill_byte;
        for (int k = 0; k < LANES; k++) begin
            if (lane_we[k])
                mem[lane_idx[k]] <= lane_wbyte[k];
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++)
            lane_rbyte[k] = mem[lane_idx[k]];
    end
endmodule

// File: rtl/bod_mode_ctrl.sv
module bod_mode_ctrl
    import bod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_we,
    input  xfer_t     size,
    input  logic      flag_byte,
    input  logic      flag_wide,
    input  logic      led_we,
    input  logic [3:0] led_bits,
    output map_mode_t mode,
    output logic [3:0] led_n
);
    map_mode_t state, state_nx;
    logic      flag;

    assign flag = (size == XFER_BYTE) ? flag_byte : flag_wide;

    // Next-state: BOOT_TO_NORMAL and NORMAL_TO_BOOT
    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_BOOT:   if (ctrl_we && flag)  state_nx = MODE_NORMAL;
            MODE_NORMAL: if (ctrl_we && !flag) state_nx = MODE_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MODE_BOOT;
        else     state <= state_nx;
    end

    always_comb begin
        mode = state;
    end

    always_ff @(posedge clk) begin
        if (rst)         led_n <= 4'hF;
        else if (led_we) led_n <= led_bits;
    end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import bod_pkg::*;
#(
    parameter int ROM_BYTES   = 16384,
    parameter int RAM_BYTES   = 524288,
    parameter int STORE_DEPTH = 256,
    localparam int STORE_AW   = $clog2(STORE_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [1:0]          bus_size,
    input  logic [23:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic [3:0]          led_n,
    input  logic                fill_en,
    input  logic [1:0]          fill_sel,
    input  logic [STORE_AW-1:0] fill_idx,
    input  logic [7:0]          fill_byte
);
    localparam int NREG = 4;
    localparam logic [BUS_AW-1:0] ROM_MASK = BUS_AW'(ROM_BYTES - 1);
    localparam logic [BUS_AW-1:0] RAM_MASK = BUS_AW'(RAM_BYTES - 1);

    function automatic logic [BUS_AW-1:0] region_mask(int g);
        case (g)
            0:       region_mask = ROM_MASK;
            1:       region_mask = RAM_MASK;
            2:       region_mask = VRAM_MASK;
            default: region_mask = MAP_MASK;
        endcase
    endfunction

    xfer_t             size;
    logic              do_wr;
    map_mode_t         mode;
    logic [BUS_AW-1:0] eff_addr;
    region_t           region;
    logic [LANES-1:0]  lanes;
    logic [LANES-1:0][7:0] wr_bytes;
    logic [LANES-1:0][7:0] sel_bytes;
    logic [LANES-1:0][7:0] store_rd  [NREG];
    logic [LANES-1:0][STORE_AW-1:0] store_idx [NREG];
    logic [31:0]       rd_word;
    logic              ctrl_we, led_we;

    assign size  = xfer_t'(bus_size);
    assign do_wr = bus_wr && !bus_rd;
    assign lanes = lane_mask(size);

    bod_region_decode #(.RAM_BYTES(RAM_BYTES)) u_dec (
        .bus_addr (bus_addr),
        .mode     (mode),
        .eff_addr (eff_addr),
        .region   (region)
    );

    // Big-endian lane split of right-justified write data
    always_comb begin
        wr_bytes = '0;
        case (size)
            XFER_BYTE: wr_bytes[0] = bus_wdata[7:0];
            XFER_WORD: begin
                wr_bytes[0] = bus_wdata[15:8];
                wr_bytes[1] = bus_wdata[7:0];
            end
            default: begin
                wr_bytes[0] = bus_wdata[31:24];
                wr_bytes[1] = bus_wdata[23:16];
                wr_bytes[2] = bus_wdata[15:8];
                wr_bytes[3] = bus_wdata[7:0];
            end
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_region
        logic [LANES-1:0] we;

        always_comb begin
            for (int k = 0; k < LANES; k++)
                store_idx[g][k] = STORE_AW'((eff_addr + BUS_AW'(k)) & region_mask(g));
        end

        if (g == 0) begin : g_ro
            assign we = '0;
        end else begin : g_rw
            assign we = (do_wr && region == region_t'(g)) ? lanes : '0;
        end

        bod_byte_store #(.DEPTH(STORE_DEPTH), .AW(STORE_AW)) u_store (
            .clk        (clk),
            .fill_en    (fill_en && fill_sel == 2'(g)),
            .fill_idx   (fill_idx),
            .fill_byte  (fill_byte),
            .lane_we    (we),
            .lane_idx   (store_idx[g]),
            .lane_wbyte (wr_bytes),
            .lane_rbyte (store_rd[g])
        );
    end

    // Read assembly
    always_comb begin
        sel_bytes = store_rd[region[1:0]];
        if (region == RGN_IO)
            sel_bytes = {LANES{8'hFF}};
        case (size)
            XFER_BYTE: rd_word = {24'h0, sel_bytes[0]};
            XFER_WORD: rd_word = {16'h0, sel_bytes[0], sel_bytes[1]};
            default:   rd_word = {sel_bytes[0], sel_bytes[1], sel_bytes[2], sel_bytes[3]};
        endcase
    end

    assign ctrl_we = do_wr && region == RGN_IO && eff_addr == CTRL_ADDR;
    assign led_we  = do_wr && region == RGN_IO && eff_addr == LED_ADDR && size == XFER_WORD;

    bod_mode_ctrl u_mode (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .size      (size),
        .flag_byte (bus_wdata[7]),
        .flag_wide (bus_wdata[15]),
        .led_we    (led_we),
        .led_bits  (bus_wdata[11:8]),
        .mode      (mode),
        .led_n     (led_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_rd;
            if (bus_rd) rd_data <= rd_word;
        end
    end
endmodule

// File: rtl/bod_checker.sv
module bod_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [1:0]  bus_size,
    input logic [23:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [3:0]  led_n
);
    logic led_attempt;
    assign led_attempt = bus_wr && !bus_rd && bus_size == 2'd1 && bus_addr == 24'h4A0000;

    AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> rd_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !rd_valid); // R10
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !led_attempt |=> $stable(led_n)); // R9
    AST_LED_LOAD: assert property (@(posedge clk) disable iff (rst)
        led_attempt |=> (led_n == $past(bus_wdata[11:8]) || $stable(led_n))); // R9
    AST_IO_BYTE_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size == 2'd0 && bus_addr[23:22] == 2'b11) |=> rd_data == 32'h000000FF); // R5
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size == 2'd0) |=> rd_data[31:8] == 24'h0); // R6
    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size == 2'd1) |=> rd_data[31:16] == 16'h0); // R6
endmodule

bind boot_overlay_decoder bod_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .led_n     (led_n)
);

// File: tb/boot_overlay_decoder_bench.sv
`timescale 1ns/1ps
module boot_overlay_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 0, bus_wr = 0;
    logic [1:0]  bus_size = 0;
    logic [23:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  led_n;
    logic        fill_en = 0;
    logic [1:0]  fill_sel = 0;
    logic [7:0]  fill_idx = 0;
    logic [7:0]  fill_byte = 0;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int   mdl [4][256];
    bit   mdl_normal;
    logic [3:0] mdl_led;

    always #2 clk = ~clk;

    boot_overlay_decoder u_boot_overlay_decoder (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .led_n(led_n), .fill_en(fill_en), .fill_sel(fill_sel), .fill_idx(fill_idx),
        .fill_byte(fill_byte)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mdl_region(logic [23:0] e);
        if (e >= 24'h800000 && e <= 24'hBFFFFF) return 0;
        if (e <= 24'h07FFFF) return 1;
        if (e >= 24'h420000 && e <= 24'h427FFF) return 2;
        if (e >= 24'h400000 && e <= 24'h4007FF) return 3;
        return 4;
    endfunction

    function automatic logic [23:0] mdl_mask(int r);
        case (r)
            0: return 24'h003FFF;
            1: return 24'h07FFFF;
            2: return 24'h007FFF;
            default: return 24'h0007FF;
        endcase
    endfunction

    task automatic access(input bit rd, input bit wr, input int sz, input logic [23:0] a,
                          input logic [31:0] d, input string tag);
        logic [23:0] e;
        logic [31:0] exp;
        int r, n;
        e = mdl_normal ? a : (a | 24'h800000);
        r = mdl_region(e);
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        exp = 0;
        for (int k = 0; k < n; k++) begin
            logic [23:0] ek;
            ek = e + 24'(k);
            if (r == 4) exp = (exp << 8) | 32'hFF;
            else exp = (exp << 8) | 32'(mdl[r][int'((ek & mdl_mask(r)) % 256)]);
        end
        bus_rd = rd; bus_wr = wr; bus_size = 2'(sz); bus_addr = a; bus_wdata = d;
        if (wr && !rd) begin
            if (r == 4) begin
                if (e == 24'hE43000) mdl_normal = (sz == 0) ? d[7] : d[15];
                if (e == 24'h4A0000 && sz == 1) mdl_led = d[11:8];
            end else if (r != 0) begin
                for (int k = 0; k < n; k++) begin
                    logic [23:0] ek;
                    ek = e + 24'(k);
                    mdl[r][int'((ek & mdl_mask(r)) % 256)] = int'((d >> (8 * (n - 1 - k))) & 32'hFF);
                end
            end
        end
        @(negedge clk);
        check(rd_valid == rd, "R10 rd_valid", 32'(rd_valid), 32'(rd));
        if (rd) check(rd_data == exp, tag, rd_data, exp);
        check(led_n == mdl_led, "R9 led_n", 32'(led_n), 32'(mdl_led));
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic rd(input int sz, input logic [23:0] a, input string tag);
        access(1, 0, sz, a, 0, tag);
    endtask

    task automatic wr(input int sz, input logic [23:0] a, input logic [31:0] d, input string tag);
        access(0, 1, sz, a, d, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mdl_normal = 0;
        mdl_led = 4'hF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rd_valid == 0, "R1 rd_valid after reset", 32'(rd_valid), 0);
        check(led_n == 4'hF, "R1 led_n after reset", 32'(led_n), 32'hF);

        // R11 preload of all regions
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 256; i++) begin
                fill_en = 1; fill_sel = 2'(r); fill_idx = 8'(i);
                fill_byte = 8'((i * (r + 3) + 17 * r) ^ 8'hA5);
                mdl[r][i] = int'(fill_byte);
                @(negedge clk);
            end
        end
        fill_en = 0;
        rd(2, 24'h000010, "R11 fill then R2 boot read hits ROM");

        // Boot mode
        rd(2, 24'h000010, "R2 boot long read forced to ROM");
        rd(1, 24'h800020, "R3 ROM word read");
        rd(0, 24'h400000, "R5 boot byte read forced to I/O");
        rd(1, 24'hE00000, "R5 I/O word all ones");
        wr(1, 24'h000010, 32'h1234, "R3 ROM write");
        rd(2, 24'h000010, "R3 ROM write discarded");
        wr(1, 24'h4A0000, 32'h0000, "R2 LED address moved by boot forcing");
        check(led_n == 4'hF, "R2 boot LED untouched", 32'(led_n), 32'hF);

        // R8 byte-flag entry into normal mode
        wr(0, 24'hE43000, 32'h80, "R8 byte write bit7 set");
        rd(2, 24'h000010, "R8 normal mode reads RAM");
        wr(2, 24'h000100, 32'hDEADBEEF, "R6 long write");
        rd(0, 24'h000100, "R6 byte 0 is MSB");
        rd(0, 24'h000103, "R6 byte 3 is LSB");
        rd(1, 24'h000102, "R6 word read low half");
        rd(2, 24'h000100, "R6 long readback");
        wr(1, 24'h000200, 32'hCAFE, "R6 word write");
        rd(2, 24'h0001FE, "R6 long spanning word write");

        // R4 region bounds
        rd(0, 24'h07FFFF, "R4 RAM last byte");
        rd(0, 24'h080000, "R4 past RAM is I/O");
        rd(2, 24'h420004, "R4 VRAM long");
        rd(0, 24'h427FFF, "R4 VRAM last byte");
        rd(0, 24'h428000, "R4 past VRAM is I/O");
        rd(1, 24'h400004, "R4 map word");
        rd(0, 24'h4007FF, "R4 map last byte");
        rd(0, 24'h400800, "R4 past map is I/O");
        rd(2, 24'h3FFFFC, "R5 I/O long all ones");
        rd(2, 24'h800000, "R3 ROM base in normal mode");

        // R7 wrap within region
        wr(2, 24'h427FFE, 32'h11223344, "R7 VRAM wrapping write");
        rd(0, 24'h420000, "R7 wrapped byte 2 at VRAM base");
        rd(2, 24'h427FFE, "R7 VRAM wrapping read");
        rd(2, 24'hBFFFFE, "R7 ROM wrapping read");
        rd(2, 24'h4007FE, "R7 map wrapping read");

        // R9 LEDs
        wr(1, 24'h4A0000, 32'h0A00, "R9 LED word write");
        check(led_n == 4'hA, "R9 LED value", 32'(led_n), 32'hA);
        wr(0, 24'h4A0000, 32'h00, "R9 LED byte write ignored");
        wr(2, 24'h4A0000, 32'h0000_0000, "R9 LED long write ignored");
        wr(1, 24'h4A0000, 32'h0500, "R9 LED second word write");

        // R10 unused I/O writes
        wr(2, 24'hE00000, 32'hFFFF_FFFF, "R10 I/O write ignored");
        rd(2, 24'h000100, "R10 RAM unchanged after I/O write");
        rd(0, 24'h000101, "R10 back-to-back read 1");
        rd(0, 24'h000102, "R10 back-to-back read 2");

        // R8 word/long flag positions
        wr(1, 24'hE43000, 32'h0080, "R8 word write bit15 clear");
        rd(2, 24'h000010, "R8 back in boot mode reads ROM");
        wr(2, 24'hE43000, 32'h0000_8000, "R8 long write bit15 set");
        rd(2, 24'h000010, "R8 normal again reads RAM");
        wr(0, 24'hE43000, 32'h7F, "R8 byte write bit7 clear");
        rd(2, 24'h000100, "R8 boot after byte clear");
        wr(1, 24'hE43000, 32'h8000, "R8 word write bit15 set");
        rd(2, 24'h000100, "R8 normal after word set");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule